// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the SPI serial clock from the faster module clock. A 13-bit control word selects one of two divide laws and holds the value for each. The linear law gives a ratio of twice a count plus one. The power-of-two law gives a ratio of two raised to an exponent. The output clock has a 50% duty cycle. It toggles only while a transfer is in progress and otherwise rests at the level set by the polarity input.

With the clock the block drives two single-cycle strobes for the shift engine. The leading strobe marks each edge that leaves the idle level. The trailing strobe marks each edge that returns to it. The divide setting is captured once, when a transfer starts. Register decode and the shift register are not part of this block.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `div_ctrl[12]` = 1 (linear law), one full serial clock period lasts 2 × (N + 1) module cycles, where N = `div_ctrl[7:0]`. Each half period lasts N + 1 cycles.
- R2: With `div_ctrl[12]` = 0 (power-of-two law), one full period lasts 2^M module cycles, where M = `div_ctrl[11:8]` and M ≥ 1. Each half period lasts 2^(M-1) cycles.
- R3: With the power-of-two law and M = 0, the ratio is 2, the same as M = 1.
- R4: While `run` is low, and during reset, `sclk` equals `cpol` and both strobes are low. During a transfer every half period has the same length.
- R5: `lead_stb` is high for exactly one cycle, in the cycle in which `sclk` has just left the idle level. `trail_stb` is high for exactly one cycle, in the cycle in which `sclk` has just returned to it. The two strobes are never high together.
- R6: The divide setting is sampled in the cycle in which `run` is first seen high. Changes to `div_ctrl` later in the same transfer have no effect on the timing.
- R7: If `run` is low at a clock edge, then after that edge `sclk` is at idle, no strobe is issued, and the divider count restarts. A later transfer therefore begins with a full first half period.
- R8: The first edge of `sclk` comes one half period after the edge that first samples `run` high. Edge k comes k half periods after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High for the length of a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| div_ctrl | input | 13 | [7:0] linear count, [11:8] exponent, [12] law select (1 = linear) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on edges that leave idle |
| trail_stb | output | 1 | One-cycle strobe on edges that return to idle |

## Verification
The bench builds the block with its default widths: an 8-bit linear count and a 4-bit exponent. This puts both ends of the linear law within reach (N = 0 and N = 255), as well as exponents from 0 to 10 and both polarity settings. The largest exponent values are not run, because they would need tens of thousands of cycles per bit. The bench also covers a divide setting rewritten in the middle of a transfer, and a transfer cut short halfway through a half period and then followed by a fresh one.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int unsigned COUNT_W_DEF = 8;
  localparam int unsigned EXPO_W_DEF  = 4;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;
endpackage

// File: rtl/sclk_ratio_calc.sv
module sclk_ratio_calc
  import sclk_pkg::*;
#(
  parameter int unsigned COUNT_W = COUNT_W_DEF,
  parameter int unsigned EXPO_W  = EXPO_W_DEF,
  parameter int unsigned HALF_W  = 16,
  localparam int unsigned CTRL_W = COUNT_W + EXPO_W + 1
) (
  input  logic [CTRL_W-1:0] div_ctrl,
  output logic [HALF_W-1:0] half_len
);
  logic [COUNT_W-1:0] count_f;
  logic [EXPO_W-1:0]  expo_f;
  div_law_e           law;
  logic [HALF_W-1:0]  lin_half;
  logic [HALF_W-1:0]  pow_half;

  assign count_f = div_ctrl[COUNT_W-1:0];
  assign expo_f  = div_ctrl[COUNT_W+EXPO_W-1:COUNT_W];
  assign law     = div_law_e'(div_ctrl[CTRL_W-1]);

  // Half period lengths in module cycles.
  always_comb begin
    lin_half = HALF_W'(count_f) + HALF_W'(1);
    if (expo_f == '0) begin
      pow_half = HALF_W'(1);
    end else begin
      pow_half = HALF_W'(1) << (expo_f - EXPO_W'(1));
    end
    half_len = (law == LAW_LINEAR) ? lin_half : pow_half;
  end
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);
  logic              active_q, active_n;
  logic [HALF_W-1:0] cnt_q, cnt_n;
  logic [HALF_W-1:0] half_q;
  logic              half_en;

  always_comb begin
    tick     = active_q && run && (cnt_q == half_q - HALF_W'(1));
    half_en  = run && !active_q;
    active_n = active_q;
    cnt_n    = cnt_q;
    if (!run) begin
      active_n = 1'b0;
      cnt_n    = '0;
    end else if (!active_q) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end else if (tick) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
    end
  end

  // Divide setting captured only at transfer start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(1);
    end else if (half_en) begin
      half_q <= half_len;
    end
  end

  p_settings_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && run) |=> $stable(half_q));
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < half_q));
  p_half_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_en |-> (half_len != '0));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_pkg::*;
#(
  parameter int unsigned COUNT_W = COUNT_W_DEF,
  parameter int unsigned EXPO_W  = EXPO_W_DEF,
  localparam int unsigned CTRL_W = COUNT_W + EXPO_W + 1,
  localparam int unsigned HALF_W = (COUNT_W + 1 > (1 << EXPO_W)) ? COUNT_W + 1 : (1 << EXPO_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic [CTRL_W-1:0] div_ctrl,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  logic [HALF_W-1:0] half_len;
  logic              tick;
  logic              phase_q, phase_n;
  logic              lead_q, lead_n;
  logic              trail_q, trail_n;

  sclk_ratio_calc #(
    .COUNT_W (COUNT_W),
    .EXPO_W  (EXPO_W),
    .HALF_W  (HALF_W)
  ) u_calc (
    .div_ctrl (div_ctrl),
    .half_len (half_len)
  );

  sclk_half_timer #(
    .HALF_W (HALF_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_len (half_len),
    .tick     (tick)
  );

  always_comb begin
    phase_n = phase_q;
    lead_n  = 1'b0;
    trail_n = 1'b0;
    if (!run) begin
      phase_n = 1'b0;
    end else if (tick) begin
      phase_n = !phase_q;
      lead_n  = !phase_q;
      trail_n = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      lead_q  <= lead_n;
      trail_q <= trail_n;
    end
  end

  assign sclk      = cpol ^ phase_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!phase_q && !lead_q && !trail_q));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && trail_q));
  p_lead_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sclk != cpol));
  p_trail_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sclk == cpol));
endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;
  logic        clk;
  logic        rst_n;
  logic        run;
  logic        cpol;
  logic [12:0] div_ctrl;
  logic        sclk;
  logic        lead_stb;
  logic        trail_stb;

  typedef struct {
    int    cyc;
    bit    lead;
    string req;
  } exp_item_t;

  exp_item_t exp_q[$];
  int total;
  int bad;
  int cyc;
  bit done;

  spi_sclk_gen i_spi_sclk_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cpol),
    .div_ctrl  (div_ctrl),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected strobes and compares cycle, kind and level.
  always @(negedge clk) begin
    if (rst_n && (lead_stb || trail_stb)) begin
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected strobe", cyc, -1);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        check(it.cyc == cyc, it.req, "strobe cycle", cyc, it.cyc);
        check(lead_stb == it.lead && trail_stb == !it.lead, "R5", "strobe kind",
              {lead_stb, trail_stb}, it.lead ? 2 : 1);
        check(sclk == (it.lead ? !cpol : cpol), "R5", "sclk at strobe",
              sclk, it.lead ? !cpol : cpol);
      end
    end
  end

  function automatic logic [12:0] lin_word(input int n);
    return {1'b1, 4'h0, 8'(n)};
  endfunction

  function automatic logic [12:0] pow_word(input int m);
    return {1'b0, 4'(m), 8'hA5};
  endfunction

  // Driver: pushes expected edges then runs the transfer.
  task automatic run_xfer(input logic [12:0] w, input int half, input int bits,
                          input bit cp, input string req, input bit change_mid);
    int base;
    @(negedge clk);
    div_ctrl = w;
    cpol = cp;
    base = cyc + 1;
    for (int k = 1; k <= 2 * bits; k++) begin
      exp_item_t it;
      it.cyc = base + k * half;
      it.lead = (k % 2) == 1;
      it.req = req;
      exp_q.push_back(it);
    end
    run = 1'b1;
    for (int i = 0; i < 2 * bits * half + 1; i++) begin
      @(posedge clk);
      if (change_mid && i == half) begin
        #1 div_ctrl = ~w;
      end
    end
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(sclk == cp, "R7", "sclk idle after stop", sclk, cp);
    @(negedge clk);
    check(exp_q.size() == 0, req, "missing strobes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    total = 0;
    bad = 0;
    done = 0;
    rst_n = 1'b0;
    run = 1'b0;
    cpol = 1'b1;
    div_ctrl = '0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b1 && !lead_stb && !trail_stb, "R4", "reset idle",
          {sclk, lead_stb, trail_stb}, 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R4", "idle before run", sclk, 1);

    run_xfer(lin_word(0), 1, 3, 1'b0, "R1", 0);
    run_xfer(lin_word(3), 4, 2, 1'b1, "R1", 0);
    run_xfer(lin_word(255), 256, 1, 1'b0, "R1", 0);
    run_xfer(pow_word(0), 1, 2, 1'b0, "R3", 0);
    run_xfer(pow_word(1), 1, 2, 1'b1, "R2", 0);
    run_xfer(pow_word(3), 4, 2, 1'b0, "R2", 0);
    run_xfer(pow_word(10), 512, 1, 1'b1, "R2", 0);
    run_xfer(lin_word(2), 3, 3, 1'b0, "R6", 1);
    run_xfer(lin_word(5), 6, 1, 1'b1, "R8", 0);

    // R7: stop in the middle of a half period.
    @(negedge clk);
    div_ctrl = lin_word(3);
    cpol = 1'b0;
    begin
      exp_item_t it;
      it.cyc = cyc + 1 + 4;
      it.lead = 1'b1;
      it.req = "R7";
      exp_q.push_back(it);
    end
    run = 1'b1;
    repeat (7) @(posedge clk);
    #1 run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R7", "sclk high before stop", sclk, 1);
    @(posedge clk);
    @(negedge clk);
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "R7", "idle one cycle after stop",
          {sclk, lead_stb, trail_stb}, 0);
    check(exp_q.size() == 0, "R7", "missing strobe", exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "R4", "quiet while idle",
          {sclk, lead_stb, trail_stb}, 0);
    // Fresh transfer after the cut: full first half period.
    run_xfer(lin_word(3), 4, 1, 1'b0, "R7", 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule